// File: doc/BRIEF.md
# Quadrature Frequency Detector with Lock Monitor

This block helps a clock recovery loop pull its local oscillator onto the frequency of incoming serial data. Each time the data input changes level, whether it rises or falls, the block captures the in-phase and quadrature oscillator phases as a 2-bit quadrant code. It then compares that code with the one captured at the previous data edge. The quadrant codes follow the Gray cycle 00, 01, 11, 10. A move of one step forward along that cycle means the oscillator is slow. A move of one step back means it is fast. From this the block drives an up or a down correction output, and it holds both low once the quadrant stops moving.

A jump of two steps cannot be given a direction, so the block discards it. The block also carries a lock monitor with an active-low flag. The flag stays low while the quadrant keeps rotating. It goes high a fixed number of reference-clock cycles after a run of consecutive quiet data edges, a span chosen to match a settling time of about 800 ns. The lock result only means something while the data is toggling: a dead input is never reported as lost lock. The analog loop filter, the oscillator and the phase detector lie outside this block. All inputs are taken as synchronous to the reference clock.

Top module: `quad_freq_detector`

## Requirements
- R1: After reset, `up_o` and `dn_o` are low and `lol_n_o` is low.
- R2: Decisions are made only at data edges of either polarity. An edge presented on `data_in` updates the outputs at the second rising clock edge after it. A quadrant change with no data edge does not move the outputs and does not replace the stored reference quadrant.
- R3: The first data edge after reset only stores the reference quadrant. It leaves `up_o` and `dn_o` low and does not add to the quiet count.
- R4: A one-step forward move {osc_i,osc_q} 00→01→11→10→00 between consecutive edges sets `up_o`=1 and `dn_o`=0. These values hold until the next decisive edge.
- R5: A one-step backward move (the reverse of the R4 order) sets `dn_o`=1 and `up_o`=0, held the same way.
- R6: An edge that captures the same quadrant as the previous edge drives both `up_o` and `dn_o` low.
- R7: A two-step jump (00↔11 or 01↔10) leaves `up_o`, `dn_o` and the quiet count unchanged. The captured code still becomes the new reference.
- R8: `up_o` and `dn_o` are never high in the same cycle.
- R9: `lol_n_o` rises exactly SETTLE_CYCLES clock cycles after the edge that brings the count of consecutive same-quadrant edges to QUIET_EDGES.
- R10: Any forward or backward move clears the quiet count and the settle timer. It drives `lol_n_o` low in the same cycle that `up_o`/`dn_o` update, even partway through the settle time.
- R11: Once high, `lol_n_o` stays high through same-quadrant edges, two-step jumps and idle data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 1 | Serial data; both level changes are sampling events |
| osc_i | input | 1 | In-phase oscillator phase level |
| osc_q | input | 1 | Quadrature oscillator phase level |
| up_o | output | 1 | Oscillator slow: raise frequency |
| dn_o | output | 1 | Oscillator fast: lower frequency |
| lol_n_o | output | 1 | Loss-of-lock flag, low while out of lock |

## Verification
A stale or wrong reference quadrant shows up at the very next data edge. The bench sees the wrong direction on `up_o`/`dn_o` two clock cycles after it drives that edge, and every decisive edge is checked at that exact cycle. A quiet count that is off by even one edge, or a settle timer that is off by one cycle, moves the rising edge of `lol_n_o`. So the bench samples the flag one cycle before and exactly at the expected release. It does this after plain quiet runs, after runs broken by a discarded jump, and after a rotation mid-settle. A reference that is updated without a data edge flips the direction reported at the following edge.

// File: rtl/qfd_pkg.sv
`timescale 1ns/1ps
package qfd_pkg;

    typedef enum logic [2:0] {
        MV_IDLE,
        MV_REF,
        MV_HOLD,
        MV_FWD,
        MV_BWD,
        MV_AMB
    } move_e;

    // position of a quadrant code along the Gray cycle 00,01,11,10
    function automatic logic [1:0] quad_pos(input logic [1:0] code);
        logic [1:0] p;
        case (code)
            2'b00:   p = 2'd0;
            2'b01:   p = 2'd1;
            2'b11:   p = 2'd2;
            default: p = 2'd3;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/qfd_edge_sampler.sv
`timescale 1ns/1ps
module qfd_edge_sampler #(
    parameter int QUAD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_in,
    input  logic [QUAD_W-1:0] quad_in,
    output logic              data_edge_o,
    output logic [QUAD_W-1:0] quad_o
);
    typedef struct packed {
        logic              data_s1;
        logic              data_s2;
        logic [QUAD_W-1:0] quad_s1;
    } smp_t;

    smp_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.data_s1 = data_in;
        st_d.data_s2 = st_q.data_s1;
        st_d.quad_s1 = quad_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_edge_o = st_q.data_s1 ^ st_q.data_s2;
    assign quad_o      = st_q.quad_s1;

    // R2
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_edge_o && $stable(data_in) |=> !data_edge_o);
endmodule

// File: rtl/qfd_rotation.sv
`timescale 1ns/1ps
module qfd_rotation
    import qfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_edge_i,
    input  logic [1:0] quad_i,
    output move_e      move_o,
    output logic       up_o,
    output logic       dn_o
);
    typedef struct packed {
        logic [1:0] ref_code;
        logic       ref_valid;
        logic       up;
        logic       dn;
    } rot_t;

    rot_t  st_d, st_q;
    logic [1:0] step;
    move_e mv;

    always_comb begin
        step = quad_pos(quad_i) - quad_pos(st_q.ref_code);
        if (!data_edge_i)          mv = MV_IDLE;
        else if (!st_q.ref_valid)  mv = MV_REF;
        else begin
            case (step)
                2'd0:    mv = MV_HOLD;
                2'd1:    mv = MV_FWD;
                2'd3:    mv = MV_BWD;
                default: mv = MV_AMB;
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        if (data_edge_i) begin
            st_d.ref_code  = quad_i;
            st_d.ref_valid = 1'b1;
        end
        case (mv)
            MV_FWD:  begin st_d.up = 1'b1; st_d.dn = 1'b0; end
            MV_BWD:  begin st_d.up = 1'b0; st_d.dn = 1'b1; end
            MV_HOLD: begin st_d.up = 1'b0; st_d.dn = 1'b0; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign move_o = mv;
    assign up_o   = st_q.up;
    assign dn_o   = st_q.dn;

    // R8
    not_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_o && dn_o));
    // R2
    up_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_o) |-> $past(data_edge_i));
    // R2
    dn_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_o) |-> $past(data_edge_i));
endmodule

// File: rtl/qfd_lock_monitor.sv
`timescale 1ns/1ps
module qfd_lock_monitor
    import qfd_pkg::*;
#(
    parameter int QUIET_EDGES   = 8,
    parameter int SETTLE_CYCLES = 100
) (
    input  logic  clk,
    input  logic  rst_n,
    input  move_e move_i,
    output logic  lol_n_o
);
    localparam int QW = $clog2(QUIET_EDGES + 1);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [QW-1:0] QUIET_FULL = QW'(QUIET_EDGES);
    localparam logic [SW-1:0] SETTLE_END = SW'(SETTLE_CYCLES - 1);

    typedef struct packed {
        logic [QW-1:0] quiet_cnt;
        logic [SW-1:0] settle_cnt;
        logic          lol_n;
    } mon_t;

    mon_t st_d, st_q;
    logic rotated;

    assign rotated = (move_i == MV_FWD) || (move_i == MV_BWD);

    always_comb begin
        st_d = st_q;
        if (rotated) begin
            st_d.quiet_cnt  = '0;
            st_d.settle_cnt = '0;
            st_d.lol_n      = 1'b0;
        end else begin
            if (move_i == MV_HOLD && st_q.quiet_cnt != QUIET_FULL)
                st_d.quiet_cnt = st_q.quiet_cnt + 1'b1;
            if (st_q.quiet_cnt == QUIET_FULL && !st_q.lol_n) begin
                st_d.settle_cnt = st_q.settle_cnt + 1'b1;
                if (st_q.settle_cnt == SETTLE_END)
                    st_d.lol_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lol_n_o = st_q.lol_n;

    // R10
    rot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rotated |=> !lol_n_o);
    // R9
    rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol_n_o) |-> $past(!rotated));
    // R9
    settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.settle_cnt <= SW'(SETTLE_CYCLES));
    // R11
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lol_n_o) |-> $past(rotated));
endmodule

// File: rtl/quad_freq_detector.sv
`timescale 1ns/1ps
module quad_freq_detector
    import qfd_pkg::*;
#(
    parameter int QUIET_EDGES   = 8,
    parameter int SETTLE_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    input  logic osc_i,
    input  logic osc_q,
    output logic up_o,
    output logic dn_o,
    output logic lol_n_o
);
    logic       data_edge;
    logic [1:0] quad;
    move_e      move;

    qfd_edge_sampler #(.QUAD_W(2)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_in    (data_in),
        .quad_in    ({osc_i, osc_q}),
        .data_edge_o(data_edge),
        .quad_o     (quad)
    );

    qfd_rotation u_rot (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_edge_i(data_edge),
        .quad_i     (quad),
        .move_o     (move),
        .up_o       (up_o),
        .dn_o       (dn_o)
    );

    qfd_lock_monitor #(
        .QUIET_EDGES  (QUIET_EDGES),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .move_i (move),
        .lol_n_o(lol_n_o)
    );

    // R10
    lol_with_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(up_o) || $rose(dn_o)) |-> !lol_n_o);
endmodule

// File: tb/sim_quad_freq_detector.sv
`timescale 1ns/1ps
module sim_quad_freq_detector;
    localparam int QE = 4;
    localparam int SC = 12;

    logic clk = 1'b0;
    logic rst_n, data_in, osc_i, osc_q;
    logic up_o, dn_o, lol_n_o;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #4 clk = ~clk;

    quad_freq_detector #(.QUIET_EDGES(QE), .SETTLE_CYCLES(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .osc_i(osc_i),
        .osc_q(osc_q), .up_o(up_o), .dn_o(dn_o), .lol_n_o(lol_n_o)
    );

    function automatic logic [1:0] gray(input int p);
        case (p & 3)
            0:       return 2'b00;
            1:       return 2'b01;
            2:       return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; data_in = 1'b0; osc_i = 1'b0; osc_q = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    // toggle data with a quadrant, sample after the second rising clock
    task automatic edge_to(input int p);
        {osc_i, osc_q} = gray(p);
        data_in = ~data_in;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 up", up_o, 0);
        chk("R1 dn", dn_o, 0);
        chk("R1 lol_n", lol_n_o, 0);
    endtask

    task automatic t_forward();
        do_reset();
        edge_to(1);
        chk("R3 first edge up", up_o, 0);
        chk("R3 first edge dn", dn_o, 0);
        for (int p = 2; p <= 5; p++) begin
            edge_to(p);
            chk("R4 fwd up", up_o, 1);
            chk("R4 fwd dn", dn_o, 0);
        end
        chk("R2 both polarities decided", up_o, 1);
    endtask

    task automatic t_backward();
        do_reset();
        edge_to(0);
        edge_to(3);
        chk("R5 bwd wrap dn", dn_o, 1);
        chk("R5 bwd wrap up", up_o, 0);
        edge_to(2);
        chk("R5 bwd dn", dn_o, 1);
        edge_to(2);
        chk("R6 same quad up", up_o, 0);
        chk("R6 same quad dn", dn_o, 0);
    endtask

    task automatic t_ambig();
        do_reset();
        edge_to(0);
        edge_to(1);
        edge_to(3);
        chk("R7 jump keeps up", up_o, 1);
        chk("R7 jump keeps dn", dn_o, 0);
        edge_to(2);
        chk("R7 jump became reference", dn_o, 1);
    endtask

    task automatic t_no_edge();
        do_reset();
        edge_to(0);
        edge_to(1);
        {osc_i, osc_q} = gray(2);
        wait_cycles(4);
        chk("R2 idle up held", up_o, 1);
        {osc_i, osc_q} = gray(3);
        wait_cycles(3);
        edge_to(2);
        chk("R2 ref not replaced", up_o, 1);
    endtask

    task automatic t_lock();
        do_reset();
        edge_to(0);
        for (int k = 0; k < QE; k++) edge_to(0);
        chk("R9 low at count full", lol_n_o, 0);
        wait_cycles(SC - 1);
        chk("R9 low one before", lol_n_o, 0);
        wait_cycles(1);
        chk("R9 high at settle", lol_n_o, 1);
        edge_to(0);
        edge_to(2);
        wait_cycles(5);
        chk("R11 stays high", lol_n_o, 1);
        edge_to(3);
        chk("R10 drop with move", lol_n_o, 0);
        chk("R10 up same cycle", up_o, 1);
    endtask

    task automatic t_ambig_count();
        do_reset();
        edge_to(0);
        for (int k = 0; k < QE - 1; k++) edge_to(0);
        edge_to(2);
        wait_cycles(SC + 2);
        chk("R7 jump not counted", lol_n_o, 0);
        edge_to(2);
        wait_cycles(SC - 1);
        chk("R7 count kept, one before", lol_n_o, 0);
        wait_cycles(1);
        chk("R7 count kept, release", lol_n_o, 1);
    endtask

    task automatic t_restart();
        do_reset();
        edge_to(0);
        for (int k = 0; k < QE; k++) edge_to(0);
        wait_cycles(3);
        edge_to(1);
        chk("R10 mid-settle low", lol_n_o, 0);
        wait_cycles(2 * SC);
        chk("R10 count restarted", lol_n_o, 0);
        for (int k = 0; k < QE; k++) edge_to(1);
        wait_cycles(SC);
        chk("R9 relock", lol_n_o, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; data_in = 1'b0; osc_i = 1'b0; osc_q = 1'b0;
        t_reset();
        t_forward();
        t_backward();
        t_ambig();
        t_no_edge();
        t_lock();
        t_ambig_count();
        t_restart();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule